// File: doc/BRIEF.md
# Multi-mode 16-bit timer/counter

This block is a 16-bit up-counter with two data registers: a period register (A) and a duty/capture register (B). A 3-bit clock-select field picks the count enable. It can be the system clock divided by 1, 2, 4, 8, 64, 512 or 2048, or the rising edges of an external count pin. A 2-bit mode field chooses one of four behaviours that share the same counter and registers:

- a free timer that clears on a period match and toggles a compare pin;
- an input-capture timer that copies the counter into B on a trigger edge;
- a one-shot pulse generator;
- a repeating pulse generator.

Software drives a plain write strobe with an address and data word. It can set the control word, load A, load B, or clear the counter. There is no stream interface: the write port has no back-pressure and every strobed write is accepted in the cycle it is presented. The counter and the B register can be read at all times on dedicated output ports. A one-cycle match pulse feeds an external interrupt controller.

Top module: `mt16_timer`

## Requirements
- R1: After reset the counter, A, B, the match pulse, the compare pin and the PWM pin are all 0. The mode is timer (code 0) and the clock select is divide-by-1 (code 0).
- R2: The write addresses are 0 for control, 1 for A and 2 for B; address 3 is ignored. In the control word, bits [1:0] are the mode, bits [4:2] are the clock select and bit 7 is the clear. Clock-select codes 0 to 6 divide the system clock by 1, 2, 4, 8, 64, 512 and 2048, so in timer mode match pulses are (A+1) times the division apart.
- R3: Any control write restarts the divider. With a division of N, the first counter step after the write's clock edge lands N edges later.
- R4: With clock-select code 7, the counter advances exactly once per rising edge of the external pin. The step happens on the third system-clock edge after the pin rises, and a pin held high gives no further steps.
- R5: When a count step finds the counter equal to A, the counter goes to 0 on that edge and the match output is high for exactly one cycle. This applies in every mode.
- R6: In timer mode (code 0) the compare pin toggles on every match. In the other modes it holds its value.
- R7: A control write with bit 7 set forces the counter to 0 on that edge. It overrides a coincident count step, suppresses that step's match, and restarts a halted one-shot.
- R8: In capture mode (code 1), a rising edge on the capture pin copies the counter into B. The value taken is the counter's value before the third system-clock edge after the pin rises. Only rising edges capture. A capture overrides a coincident software write to B.
- R9: In the pulse modes (codes 2 and 3) the PWM pin is high while the counter is below B. It is low in timer and capture modes, and always low when B is 0.
- R10: In one-shot mode (code 2), the counter stops at 0 after the match that ends the first period, with the PWM pin low. It stays there until the next control write.
- R11: In repeat mode (code 3) the counter wraps on each match and keeps producing pulses.
- R12: Outside capture mode a capture-pin edge leaves B unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_pin | input | 1 | External count clock, asynchronous |
| cap_pin | input | 1 | Capture trigger, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 A, 2 B |
| wr_data | input | 16 | Write data |
| match_irq | output | 1 | One-cycle pulse on a period match |
| cmp_out | output | 1 | Compare pin, toggles on match in timer mode |
| pwm_out | output | 1 | Pulse-generator output |
| count_val | output | 16 | Current counter value |
| capture_val | output | 16 | Current B register value |

## Verification
The period function is driven through every internal division with small A values, including A=0. A wrong divider tap or an off-by-one in the match-and-clear loop therefore shows up as a different pulse spacing. The external pin is toggled slowly and then held high, which separates level counting from edge counting. Capture is triggered at a known counter value, held, released and then repeated in timer mode, to tell edge capture apart from level capture and from mode-blind capture. The pulse modes run with B inside the period and with B=0: one-shot halting and repeat wrapping give different high-sample counts and match counts over the same window.

// File: rtl/mt16_pkg.sv
package mt16_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER   = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_ONESHOT = 2'd2,
    MODE_REPEAT  = 2'd3
  } mt_mode_e;

  localparam int unsigned CSEL_W   = 3;
  localparam logic [2:0]  CSEL_EXT = 3'd7;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_A    = 2'd1;
  localparam logic [1:0] ADDR_B    = 2'd2;

  localparam int unsigned CTRL_CLR_BIT = 7;

  // log2 of the division for each internal clock-select code
  function automatic int unsigned div_shift(logic [2:0] sel);
    case (sel)
      3'd0:    return 0;
      3'd1:    return 1;
      3'd2:    return 2;
      3'd3:    return 3;
      3'd4:    return 6;
      3'd5:    return 9;
      3'd6:    return 11;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/mt16_edge_sync.sv
module mt16_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R4: one step per edge, never a two-cycle enable
  a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/mt16_prescaler.sv
module mt16_prescaler
  import mt16_pkg::*;
#(
  parameter int unsigned PSC_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CSEL_W-1:0] sel,
  input  logic              ext_rise,
  output logic              tick
);

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] mask_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       psc_q <= '0;
    else if (restart) psc_q <= '0;
    else              psc_q <= psc_q + 1'b1;
  end

  assign mask_c = PSC_W'((32'd1 << div_shift(sel)) - 32'd1);
  assign tick   = (sel == CSEL_EXT) ? ext_rise : ((psc_q & mask_c) == mask_c);

  // R2/R3: divided enables are isolated single-cycle pulses
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != 3'd0 && sel != CSEL_EXT && !restart) |=> !tick);

endmodule

// File: rtl/mt16_core.sv
module mt16_core
  import mt16_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cap_rise,
  input  mt_mode_e         mode,
  input  logic [CNT_W-1:0] a_val,
  input  logic             restart,
  input  logic             clr,
  input  logic             b_wr,
  input  logic [CNT_W-1:0] b_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] b_val,
  output logic             match_irq,
  output logic             cmp_out,
  output logic             pwm_out
);

  logic [CNT_W-1:0] cnt_q, b_q;
  logic             halted_q, irq_q, cmp_q;
  logic             step, at_top, hit, ppg;

  assign step   = tick && !halted_q;
  assign at_top = (cnt_q == a_val);
  assign hit    = step && at_top && !clr;
  assign ppg    = (mode == MODE_ONESHOT) || (mode == MODE_REPEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (step) cnt_q <= at_top ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      cmp_q    <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      irq_q <= hit;
      if (hit && mode == MODE_TIMER) cmp_q <= ~cmp_q;
      if (restart)                                halted_q <= 1'b0;
      else if (hit && mode == MODE_ONESHOT)       halted_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                b_q <= '0;
    else if (mode == MODE_CAPTURE && cap_rise) b_q <= cnt_q;
    else if (b_wr)                             b_q <= b_wdata;
  end

  assign cnt       = cnt_q;
  assign b_val     = b_q;
  assign match_irq = irq_q;
  assign cmp_out   = cmp_q;
  assign pwm_out   = ppg && !halted_q && (cnt_q < b_q);

  // R5: a match leaves the counter at zero
  a_r5_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |-> (cnt_q == '0));

  // R2: the counter moves only by one step up or back to zero
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));

  // R6: the compare pin changes only together with a match
  a_r6_cmp_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_q != $past(cmp_q)) |-> match_irq);

  // R10: a halted one-shot holds its counter until restarted
  a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/mt16_timer.sv
module mt16_timer
  import mt16_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PSC_W     = 11,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_pin,
  input  logic             cap_pin,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             match_irq,
  output logic             cmp_out,
  output logic             pwm_out,
  output logic [CNT_W-1:0] count_val,
  output logic [CNT_W-1:0] capture_val
);

  localparam int unsigned N_PINS = 2;

  mt_mode_e          mode_q;
  logic [CSEL_W-1:0] sel_q;
  logic [CNT_W-1:0]  a_q;
  logic              ctrl_wr, clr, tick;
  logic [N_PINS-1:0] pins, rises;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign clr     = ctrl_wr && wr_data[CTRL_CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_TIMER;
      sel_q  <= '0;
      a_q    <= '0;
    end else begin
      if (ctrl_wr) begin
        mode_q <= mt_mode_e'(wr_data[1:0]);
        sel_q  <= wr_data[4:2];
      end
      if (wr_en && wr_addr == ADDR_A) a_q <= wr_data;
    end
  end

  assign pins = {cap_pin, ext_clk_pin};

  for (genvar g = 0; g < N_PINS; g++) begin : g_sync
    mt16_edge_sync #(.STAGES(SYNC_STGS)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pins[g]),
      .rise (rises[g])
    );
  end

  mt16_prescaler #(.PSC_W(PSC_W)) i_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ctrl_wr),
    .sel     (sel_q),
    .ext_rise(rises[0]),
    .tick    (tick)
  );

  mt16_core #(.CNT_W(CNT_W)) i_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cap_rise (rises[1]),
    .mode     (mode_q),
    .a_val    (a_q),
    .restart  (ctrl_wr),
    .clr      (clr),
    .b_wr     (wr_en && wr_addr == ADDR_B),
    .b_wdata  (wr_data),
    .cnt      (count_val),
    .b_val    (capture_val),
    .match_irq(match_irq),
    .cmp_out  (cmp_out),
    .pwm_out  (pwm_out)
  );

  // R9: no PWM activity outside the pulse modes
  a_r9_pwm_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TIMER || mode_q == MODE_CAPTURE) |-> !pwm_out);

endmodule

// File: tb/test_mt16_timer.sv
module test_mt16_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, ext_clk_pin, cap_pin, wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic        match_irq, cmp_out, pwm_out;
  logic [15:0] count_val, capture_val;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mt16_timer i_mt16_timer (
    .clk(clk), .rst_n(rst_n), .ext_clk_pin(ext_clk_pin), .cap_pin(cap_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .match_irq(match_irq), .cmp_out(cmp_out), .pwm_out(pwm_out),
    .count_val(count_val), .capture_val(capture_val)
  );

  // period table: clock select, A, expected match spacing (R2)
  localparam logic [2:0] T_SEL [7] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6};
  localparam int         T_A   [7] = '{4, 3, 2, 1, 1, 0, 1};
  localparam int         T_PER [7] = '{5, 8, 12, 16, 128, 512, 4096};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] ctrl(bit clr, logic [2:0] sel, logic [1:0] mode);
    return {8'h00, clr, 2'b00, sel, mode};
  endfunction

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!match_irq && n < 20000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, c1, hi, irqs;
    rst_n = 1'b0; ext_clk_pin = 1'b0; cap_pin = 1'b0;
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = 16'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 count", int'(count_val), 0);
    chk("R1 capture", int'(capture_val), 0);
    chk("R1 outputs", int'({match_irq, cmp_out, pwm_out}), 0);

    // R2/R5/R6 period table
    for (int i = 0; i < 7; i++) begin
      wr(2'd1, 16'(T_A[i]));
      wr(2'd0, ctrl(1'b1, T_SEL[i], 2'd0));
      wait_irq(n);
      chk("R5 cleared at match", int'(count_val), 0);
      c1 = int'(cmp_out);
      wait_irq(n);
      chk("R2 match spacing", n, T_PER[i]);
      chk("R6 cmp toggles", int'(cmp_out), 1 - c1);
    end

    // R3 divider restart, divide by 8
    wr(2'd1, 16'hFFFF);
    wr(2'd0, ctrl(1'b1, 3'd3, 2'd0));
    repeat (7) @(negedge clk);
    chk("R3 before first tick", int'(count_val), 0);
    @(negedge clk);
    chk("R3 first tick", int'(count_val), 1);
    repeat (8) @(negedge clk);
    chk("R3 second tick", int'(count_val), 2);

    // R7 clear beats running count
    wr(2'd0, ctrl(1'b0, 3'd0, 2'd0));
    repeat (20) @(negedge clk);
    wr(2'd0, ctrl(1'b1, 3'd0, 2'd0));
    chk("R7 clear", int'(count_val), 0);

    // R4 external clock
    wr(2'd0, ctrl(1'b1, 3'd7, 2'd0));
    for (int k = 0; k < 5; k++) begin
      ext_clk_pin = 1'b1; repeat (4) @(negedge clk);
      ext_clk_pin = 1'b0; repeat (4) @(negedge clk);
    end
    chk("R4 edge count", int'(count_val), 5);
    ext_clk_pin = 1'b1; repeat (20) @(negedge clk);
    chk("R4 held high", int'(count_val), 6);
    ext_clk_pin = 1'b0;

    // R8 capture
    wr(2'd0, ctrl(1'b1, 3'd0, 2'd1));
    repeat (3) @(negedge clk);
    cap_pin = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8 captured value", int'(capture_val), 5);
    repeat (10) @(negedge clk);
    chk("R8 held level no recapture", int'(capture_val), 5);
    cap_pin = 1'b0; repeat (10) @(negedge clk);
    chk("R8 falling no capture", int'(capture_val), 5);

    // R12 capture ignored in timer mode
    wr(2'd0, ctrl(1'b0, 3'd0, 2'd0));
    wr(2'd2, 16'h1234);
    cap_pin = 1'b1; repeat (6) @(negedge clk);
    cap_pin = 1'b0; repeat (6) @(negedge clk);
    chk("R12 B unchanged", int'(capture_val), 16'h1234);

    // R9 pwm low in timer mode
    wr(2'd1, 16'd9);
    wr(2'd2, 16'd4);
    hi = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); hi += int'(pwm_out); end
    chk("R9 pwm in timer mode", hi, 0);

    // R10 one-shot
    wr(2'd0, ctrl(1'b1, 3'd0, 2'd2));
    chk("R9 pwm high below B", int'(pwm_out), 1);
    repeat (4) @(negedge clk);
    chk("R9 pwm low at B", int'(pwm_out), 0);
    repeat (6) @(negedge clk);
    chk("R10 end match", int'(match_irq), 1);
    repeat (10) @(negedge clk);
    chk("R10 halted count", int'(count_val), 0);
    chk("R10 halted pwm", int'(pwm_out), 0);
    wr(2'd0, ctrl(1'b1, 3'd0, 2'd2));
    chk("R7 restart one-shot", int'(pwm_out), 1);

    // R11 repeat
    wr(2'd0, ctrl(1'b1, 3'd0, 2'd3));
    hi = 0; irqs = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); hi += int'(pwm_out); irqs += int'(match_irq);
    end
    chk("R11 pwm high samples", hi, 8);
    chk("R11 match count", irqs, 2);
    wr(2'd2, 16'd0);
    hi = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); hi += int'(pwm_out); end
    chk("R9 B zero", hi, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule